// File: doc/BRIEF.md
# Teletext Request Window Generator

This block produces the per-line request strobe that tells an upstream teletext source when to hand over data bits. Each video line opens with a one-clock line-start pulse. A fixed number of pixel clocks later, a nominal window opens. Its length in clocks matches the nominal payload of 360 teletext bits at the configured bit rate. Two 4-bit offsets taken from an 8-bit control byte adjust this window. The upper nibble delays the opening edge. The lower nibble pulls the closing edge earlier and so trims the payload below 360 bits.

When the trim nibble is zero, the closing edge follows the opening edge, so moving the start never changes the window length. The control byte and the per-line teletext qualifier are both captured on the line-start pulse. A write made partway through a line therefore never disturbs the window in progress. A line whose qualifier was low at its start produces no request.

Top module: `teletext_req_gen`

## Requirements
- R1: After reset `ttx_req` is low and stays low until the first `line_start` pulse has been taken.
- R2: Let the edge where `line_start` is sampled high be edge 0. `ttx_req` first reads high after edge START_CLKS + r + 1, where r is `ctrl_reg[7:4]` as an unsigned 0 to 15.
- R3: `ttx_req` stays high for exactly WIN_CLKS - f consecutive clocks, where f is `ctrl_reg[3:0]` as an unsigned 0 to 15. It is then low for the rest of the line. If f is at least WIN_CLKS, no request is made.
- R4: With f = 0, the high time is WIN_CLKS clocks for every value of r, so the closing edge moves with the opening edge.
- R5: `ttx_line_en` is sampled only on `line_start`. A line that starts with it low yields no request. Changes to it later in the line have no effect until the next `line_start`.
- R6: `ctrl_reg` is sampled only on `line_start`. A value written partway through a line first takes effect on the next line.
- R7: Within a line, the request is a single contiguous pulse.
- R8: An active-low reset asserted inside a window forces `ttx_req` low at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | One-clock pulse marking the start of a line |
| ttx_line_en | input | 1 | High when the line starting now carries teletext |
| ctrl_reg | input | 8 | [7:4] opening delay, [3:0] closing trim, both in clocks |
| ttx_req | output | 1 | Teletext data request window |

## Verification
The hardest case to reach is a control write or a qualifier change that lands inside a window already running. It must leave that line alone and shape only the following one. The bench drives a line with one control byte and qualifier, then changes both a few clocks after the line-start pulse. It checks the window position and length of that line against the old values and of the next line against the new ones. A reset inside an open window, followed by a long idle stretch with no line-start pulse, covers the forced-low and idle cases.

// File: rtl/ttx_req_pkg.sv
package ttx_req_pkg;

    // Width of each offset field in the control byte.
    localparam int OFS_W = 4;

    typedef logic [OFS_W-1:0] ofs_t;

    // Packed so that rise lands on ctrl[7:4] and trim on ctrl[3:0].
    typedef struct packed {
        ofs_t rise;
        ofs_t trim;
    } edge_cfg_t;

endpackage

// File: rtl/ttx_line_timer.sv
module ttx_line_timer #(
    parameter int CNT_W   = 11,
    parameter int CNT_MAX = 1700
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start,
    output logic             running,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(CNT_MAX);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } timer_t;

    timer_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (line_start) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = '0;
        end else if (tmr_q.run && (tmr_q.cnt != CNT_LIMIT)) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign running = tmr_q.run;
    assign cnt     = tmr_q.cnt;

endmodule

// File: rtl/ttx_edge_calc.sv
module ttx_edge_calc
    import ttx_req_pkg::*;
#(
    parameter int START_CLKS = 244,
    parameter int WIN_CLKS   = 1400,
    parameter int CNT_W      = 11
) (
    input  edge_cfg_t        cfg,
    output logic [CNT_W-1:0] open_pos,
    output logic [CNT_W-1:0] close_pos
);

    localparam int OFS_MAX = (1 << OFS_W) - 1;
    localparam logic [CNT_W-1:0] START_V = CNT_W'(START_CLKS);
    localparam logic [CNT_W-1:0] WIN_V   = CNT_W'(WIN_CLKS);

    logic [CNT_W-1:0] width;

    generate
        if (WIN_CLKS > OFS_MAX) begin : g_no_clamp
            // The largest trim can never exhaust the window.
            always_comb width = WIN_V - CNT_W'(cfg.trim);
        end else begin : g_clamp
            always_comb begin
                if (CNT_W'(cfg.trim) >= WIN_V) begin
                    width = '0;
                end else begin
                    width = WIN_V - CNT_W'(cfg.trim);
                end
            end
        end
    endgenerate

    always_comb begin
        open_pos  = START_V + CNT_W'(cfg.rise);
        close_pos = open_pos + width;
    end

endmodule

// File: rtl/teletext_req_gen.sv
module teletext_req_gen
    import ttx_req_pkg::*;
#(
    parameter int START_CLKS = 244,
    parameter int WIN_CLKS   = 1400
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_start,
    input  logic       ttx_line_en,
    input  logic [7:0] ctrl_reg,
    output logic       ttx_req
);

    localparam int OFS_MAX = (1 << OFS_W) - 1;
    localparam int CNT_MAX = START_CLKS + OFS_MAX + WIN_CLKS + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        edge_cfg_t cfg;
        logic      line_on;
        logic      req;
    } state_t;

    state_t st_d, st_q;

    logic             running;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] open_pos;
    logic [CNT_W-1:0] close_pos;

    ttx_line_timer #(
        .CNT_W   (CNT_W),
        .CNT_MAX (CNT_MAX)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .running    (running),
        .cnt        (cnt)
    );

    ttx_edge_calc #(
        .START_CLKS (START_CLKS),
        .WIN_CLKS   (WIN_CLKS),
        .CNT_W      (CNT_W)
    ) u_edges (
        .cfg       (st_q.cfg),
        .open_pos  (open_pos),
        .close_pos (close_pos)
    );

    always_comb begin
        st_d = st_q;
        // Shadow the control byte and qualifier only at the line boundary.
        if (line_start) begin
            st_d.cfg     = edge_cfg_t'(ctrl_reg);
            st_d.line_on = ttx_line_en;
        end
        st_d.req = running && st_q.line_on &&
                   (cnt >= open_pos) && (cnt < close_pos);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ttx_req = st_q.req;

endmodule

// File: rtl/teletext_req_gen_chk.sv
module teletext_req_gen_chk #(
    parameter int START_CLKS = 244,
    parameter int WIN_CLKS   = 1400
) (
    input logic       clk,
    input logic       rst_n,
    input logic       line_start,
    input logic       ttx_line_en,
    input logic [7:0] ctrl_reg,
    input logic       ttx_req
);

    logic [31:0] since_line;
    logic [31:0] high_run;
    logic [3:0]  sh_rise;
    logic [3:0]  sh_trim;
    logic        sh_on;
    logic        seen_line;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_line <= '0;
            high_run   <= '0;
            sh_rise    <= '0;
            sh_trim    <= '0;
            sh_on      <= 1'b0;
            seen_line  <= 1'b0;
        end else begin
            if (line_start) begin
                since_line <= '0;
                sh_rise    <= ctrl_reg[7:4];
                sh_trim    <= ctrl_reg[3:0];
                sh_on      <= ttx_line_en;
                seen_line  <= 1'b1;
            end else if (since_line != 32'hFFFF_FFFF) begin
                since_line <= since_line + 1;
            end
            high_run <= ttx_req ? high_run + 1 : '0;
        end
    end

    int exp_width;
    always_comb begin
        exp_width = (int'(sh_trim) >= WIN_CLKS) ? 0 : WIN_CLKS - int'(sh_trim);
    end

    assert_idle_until_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_line |-> !ttx_req);

    // Opening edge position uses the byte shadowed at line start (R6).
    assert_open_pos_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ttx_req) |-> (since_line == 32'(START_CLKS + int'(sh_rise) + 1)));

    assert_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ttx_req) |-> (high_run == 32'(exp_width)));

    assert_track_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ttx_req) && (sh_trim == 4'd0)) |-> (high_run == 32'(WIN_CLKS)));

    assert_qualifier_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_on |=> !ttx_req);

endmodule

bind teletext_req_gen teletext_req_gen_chk #(
    .START_CLKS (START_CLKS),
    .WIN_CLKS   (WIN_CLKS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_start  (line_start),
    .ttx_line_en (ttx_line_en),
    .ctrl_reg    (ctrl_reg),
    .ttx_req     (ttx_req)
);

// File: tb/teletext_req_gen_tb.sv
module teletext_req_gen_tb;

    localparam int START_CLKS = 244;
    localparam int WIN_CLKS   = 1400;
    localparam int LINE_CLKS  = 1728;
    localparam int NVEC       = 8;

    // Each entry: {qualifier, control byte}.
    localparam logic [8:0] VEC [NVEC] = '{
        9'h1_00, 9'h1_50, 9'h1_05, 9'h1_F0,
        9'h1_0F, 9'h1_FF, 9'h1_3A, 9'h0_77
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_start = 1'b0;
    logic       ttx_line_en = 1'b0;
    logic [7:0] ctrl_reg = 8'h00;
    logic       ttx_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    teletext_req_gen #(
        .START_CLKS (START_CLKS),
        .WIN_CLKS   (WIN_CLKS)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_start  (line_start),
        .ttx_line_en (ttx_line_en),
        .ctrl_reg    (ctrl_reg),
        .ttx_req     (ttx_req)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_first(input logic [7:0] c);
        return START_CLKS + int'(c[7:4]) + 1;
    endfunction

    function automatic int exp_width(input logic [7:0] c);
        return (int'(c[3:0]) >= WIN_CLKS) ? 0 : WIN_CLKS - int'(c[3:0]);
    endfunction

    // Runs one line. Ten clocks after line start the inputs switch to the
    // mid values. Returns the first high index, the high count and the edges.
    task automatic run_line(input logic [7:0] c, input bit en,
                            input logic [7:0] c_mid, input bit en_mid,
                            output int first, output int count, output int rises);
        bit prev = 1'b0;
        first = -1; count = 0; rises = 0;
        @(negedge clk);
        ctrl_reg = c; ttx_line_en = en; line_start = 1'b1;
        for (int k = 0; k < LINE_CLKS; k++) begin
            @(negedge clk);
            if (k == 0) line_start = 1'b0;
            if (k == 10) begin ctrl_reg = c_mid; ttx_line_en = en_mid; end
            if (ttx_req) begin
                count++;
                if (first < 0) first = k;
                if (!prev) rises++;
            end
            prev = ttx_req;
        end
    endtask

    initial begin
        int f, n, r;
        logic [7:0] c;
        bit en;

        repeat (3) @(negedge clk);
        check(ttx_req == 1'b0, "R1 reset", int'(ttx_req), 0);
        rst_n = 1'b1;
        repeat (50) @(negedge clk);
        check(ttx_req == 1'b0, "R1 idle", int'(ttx_req), 0);

        // Table walk.
        for (int i = 0; i < NVEC; i++) begin
            c  = VEC[i][7:0];
            en = VEC[i][8];
            run_line(c, en, c, en, f, n, r);
            if (en) begin
                check(f == exp_first(c), "R2 open edge", f, exp_first(c));
                check(n == exp_width(c), "R3 width", n, exp_width(c));
                check(r == 1, "R7 single pulse", r, 1);
                if (c[3:0] == 4'd0)
                    check(n == WIN_CLKS, "R4 tracking", n, WIN_CLKS);
            end else begin
                check(n == 0, "R5 no request", n, 0);
            end
        end

        // Mid-line control write: old byte governs this line, new one the next.
        run_line(8'h20, 1'b1, 8'hC7, 1'b1, f, n, r);
        check(f == exp_first(8'h20), "R6 old open", f, exp_first(8'h20));
        check(n == exp_width(8'h20), "R6 old width", n, exp_width(8'h20));
        run_line(8'hC7, 1'b1, 8'hC7, 1'b1, f, n, r);
        check(f == exp_first(8'hC7), "R6 new open", f, exp_first(8'hC7));
        check(n == exp_width(8'hC7), "R6 new width", n, exp_width(8'hC7));

        // Qualifier dropped mid-line: full window still made.
        run_line(8'h41, 1'b1, 8'h41, 1'b0, f, n, r);
        check(n == exp_width(8'h41), "R5 drop ignored", n, exp_width(8'h41));
        // Qualifier raised mid-line: no request on this line.
        run_line(8'h41, 1'b0, 8'h41, 1'b1, f, n, r);
        check(n == 0, "R5 raise ignored", n, 0);

        // Reset inside an open window.
        @(negedge clk);
        ctrl_reg = 8'h00; ttx_line_en = 1'b1; line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        repeat (START_CLKS + 20) @(negedge clk);
        check(ttx_req == 1'b1, "R8 window open", int'(ttx_req), 1);
        rst_n = 1'b0;
        #1;
        check(ttx_req == 1'b0, "R8 forced low", int'(ttx_req), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n = 0;
        for (int k = 0; k < LINE_CLKS + 200; k++) begin
            @(negedge clk);
            if (ttx_req) n++;
        end
        check(n == 0, "R1 idle after reset", n, 0);

        // Shadow was cleared by reset; next line works from the new byte.
        run_line(8'h93, 1'b1, 8'h93, 1'b1, f, n, r);
        check(f == exp_first(8'h93), "R2 after reset", f, exp_first(8'h93));
        check(n == exp_width(8'h93), "R3 after reset", n, exp_width(8'h93));

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule